// File: doc/BRIEF.md
# Pulse Wave Channel Core

This block produces one channel of a rectangular wave whose duty cycle can be chosen from four patterns. Software programs it through four write-only byte registers, selected by a 2-bit index: a control byte that holds the duty select, a sweep byte that this core accepts and discards, a low period byte, and a high byte that carries the top three period bits together with a length-load index. The block has no readback path. An 11-bit down-counter divides the APU-rate enable, which fires on every second CPU clock. Each time the counter reloads, an 8-step sequencer moves one position. The sequencer's bit for the chosen duty then gates an externally supplied 4-bit volume onto the sample output.

The envelope generator, the sweep unit, the length counter and the mixer sit outside the core. They connect to it only through the volume, sweep-mute and length-nonzero inputs and through the restart and length-load outputs. A register write is a single-cycle strobe. It is always accepted and no back-pressure exists, so the writer never waits. The write lands on the next clock edge whether or not the APU enable is high on that cycle. The sample output is a plain level with no handshake; the mixer samples it whenever it needs to.

Top module: `pulse_channel`

## Requirements
- R1: While reset is held and on the first cycle after it, the period register, the duty select, the step position and the countdown are all zero, and `sample` is 0.
- R2: On each cycle with `apu_ce` high, the countdown decrements when it is nonzero. When it is zero, it reloads the period value held before that edge and the sequencer advances one step. When `apu_ce` is low, the countdown holds its value.
- R3: The step position moves downward with wraparound, so the sequence read is 0,7,6,5,4,3,2,1,0.
- R4: Index 0 (`wr_addr`=0) loads the duty select from `wr_data[7:6]`. For step s, the sequencer bit is 1 under these conditions: duty 0 when s=7; duty 1 when s is 6 or 7; duty 2 when s is 4 to 7; duty 3 when s is 0 to 5.
- R5: A write to index 0 changes the duty on the next edge and leaves the step position where it is.
- R6: A write to index 3 loads period bits 10:8 from `wr_data[2:0]` and sets the step to 0 on the next edge. It leaves the countdown value untouched. The step reset takes priority over an advance on that same edge. `env_restart` is high during the cycle of the strobe.
- R7: A write to index 2 loads period bits 7:0 from `wr_data`.
- R8: `sample` equals `vol_in` when all four of these hold: the sequencer bit is 1, `sweep_mute` is low, `len_nz` is high, and the period is at least 8. Otherwise `sample` is 0.
- R9: `len_load` is high during the cycle of a strobe to index 3. While `len_load` is high, `len_index` equals `wr_data[7:3]`.
- R10: A write to index 1 changes no state, and `sample` behaves exactly as if the write had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| apu_ce | input | 1 | APU-cycle enable, high every second clock |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 2 | Register index 0..3 |
| wr_data | input | 8 | Register write data |
| vol_in | input | 4 | Volume from the envelope unit |
| len_nz | input | 1 | Length counter is nonzero |
| sweep_mute | input | 1 | Sweep unit requests silence |
| sample | output | 4 | Gated sample to the mixer |
| env_restart | output | 1 | Envelope restart pulse |
| len_load | output | 1 | Length counter load strobe |
| len_index | output | 5 | Length table index, valid with len_load |

## Verification
The core is driven at several periods: a mid-range value, the boundary value 8, which must sound, and the value 7, which must be silent. Each of the four duties is run, and the duty is switched in the middle of a sequence, which separates a duty change that keeps the step position from one that resets it. High-byte writes are issued while the countdown is mid-way, which separates a restart that clears only the step from one that also clears the divider. A stretch with the enable held low shows that the timer holds. The mute inputs are toggled, and sweep-register writes are issued, to show the gate terms and the discarded register.

// File: rtl/pulse_pkg.sv
package pulse_pkg;
  localparam int PERIOD_W   = 11;
  localparam int STEP_W     = 3;
  localparam int VOL_W      = 4;
  localparam int MIN_PERIOD = 8;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_SWEEP = 2'd1,
    SEL_PLO   = 2'd2,
    SEL_PHI   = 2'd3
  } reg_sel_e;

  function automatic logic duty_bit(input logic [1:0] duty, input logic [STEP_W-1:0] step);
    case (duty)
      2'd0:    duty_bit = (step == 3'd7);
      2'd1:    duty_bit = (step >= 3'd6);
      2'd2:    duty_bit = (step >= 3'd4);
      default: duty_bit = (step <  3'd6);
    endcase
  endfunction
endpackage

// File: rtl/pulse_regs.sv
module pulse_regs
  import pulse_pkg::*;
#(
  parameter int PW = PERIOD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic [1:0]    duty,
  output logic [PW-1:0] period,
  output logic          restart
);
  localparam int HI_W = PW - 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty   <= '0;
      period <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_CTRL: duty <= wr_data[7:6];
        SEL_PLO:  period[7:0] <= wr_data;
        SEL_PHI:  period[PW-1:8] <= wr_data[HI_W-1:0];
        default:  ;
      endcase
    end
  end

  assign restart = wr_en && (reg_sel_e'(wr_addr) == SEL_PHI);

  p_sweep_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> ($stable(period) && $stable(duty)));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_pkg::*;
#(
  parameter int PW = PERIOD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apu_ce,
  input  logic [PW-1:0] period,
  output logic          advance
);
  logic [PW-1:0] cnt;

  assign advance = apu_ce && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (advance)  cnt <= period;
    else if (apu_ce)   cnt <= cnt - 1'b1;
  end

  p_timer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !apu_ce |=> $stable(cnt));
  p_timer_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (apu_ce && cnt == '0) |=> (cnt == $past(period)));
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
  import pulse_pkg::*;
#(
  parameter int SW = STEP_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic       restart,
  input  logic [1:0] duty,
  output logic       seq_bit
);
  logic [SW-1:0] step;

  always_ff @(posedge clk) begin
    if (!rst_n)       step <= '0;
    else if (restart) step <= '0;
    else if (advance) step <= step - 1'b1;
  end

  assign seq_bit = duty_bit(duty, step);

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart) |=> (step == SW'($past(step) - 1'b1)));
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (step == '0));
  p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> $stable(step));
endmodule

// File: rtl/pulse_channel.sv
module pulse_channel
  import pulse_pkg::*;
#(
  parameter int PW   = PERIOD_W,
  parameter int VW   = VOL_W,
  parameter int MINP = MIN_PERIOD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apu_ce,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [VW-1:0] vol_in,
  input  logic          len_nz,
  input  logic          sweep_mute,
  output logic [VW-1:0] sample,
  output logic          env_restart,
  output logic          len_load,
  output logic [4:0]    len_index
);
  logic [1:0]    duty;
  logic [PW-1:0] period;
  logic          restart;
  logic          advance;
  logic          seq_bit;
  logic          audible;

  pulse_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .duty(duty), .period(period), .restart(restart)
  );

  pulse_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .apu_ce(apu_ce), .period(period), .advance(advance)
  );

  pulse_seq #(.SW(STEP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .advance(advance), .restart(restart),
    .duty(duty), .seq_bit(seq_bit)
  );

  assign audible     = seq_bit && !sweep_mute && len_nz && (period >= PW'(MINP));
  assign sample      = audible ? vol_in : '0;
  assign env_restart = restart;
  assign len_load    = restart;
  assign len_index   = wr_data[7:3];

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_mute || !len_nz || period < PW'(MINP)) |-> (sample == '0));
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (sample == '0));
endmodule

// File: tb/sim_pulse_channel.sv
`timescale 1ns/1ps
module sim_pulse_channel;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       apu_ce = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] vol_in = 0;
  logic       len_nz = 0;
  logic       sweep_mute = 0;
  logic [3:0] sample;
  logic       env_restart, len_load;
  logic [4:0] len_index;

  pulse_channel u0 (
    .clk(clk), .rst_n(rst_n), .apu_ce(apu_ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vol_in(vol_in), .len_nz(len_nz), .sweep_mute(sweep_mute),
    .sample(sample), .env_restart(env_restart), .len_load(len_load), .len_index(len_index)
  );

  always #5 clk = ~clk;

  int tbl [4][8] = '{'{0,0,0,0,0,0,0,1}, '{0,0,0,0,0,0,1,1},
                     '{0,0,0,0,1,1,1,1}, '{1,1,1,1,1,1,0,0}};
  int m_cnt, m_step, m_period, m_duty;
  int n_checks = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit ce_alt = 1;

  always @(posedge clk) begin
    bit adv;
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_step = 0; m_period = 0; m_duty = 0;
    end else begin
      adv = 0;
      if (apu_ce) begin
        if (m_cnt == 0) begin m_cnt = m_period; adv = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (wr_en && wr_addr == 0) m_duty = wr_data[7:6];
      if (wr_en && wr_addr == 2) m_period = (m_period & 32'h700) | wr_data;
      if (wr_en && wr_addr == 3) m_period = (m_period & 32'hFF) | ((wr_data & 7) << 8);
      if (wr_en && wr_addr == 3) m_step = 0;
      else if (adv) m_step = (m_step + 7) % 8;
    end
    if (cycles > 150000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int es;
    bit wr3;
    es = (rst_n && tbl[m_duty][m_step] == 1 && !sweep_mute && len_nz && m_period >= 8) ? vol_in : 0;
    if (!rst_n) es = 0;
    chk(cur_req, "sample", sample, es);
    wr3 = wr_en && wr_addr == 3;
    chk("R6", "env_restart", env_restart, wr3);
    chk("R9", "len_load", len_load, wr3);
    if (wr3) chk("R9", "len_index", len_index, wr_data[7:3]);
  endtask

  task automatic cyc(bit w = 0, logic [1:0] a = 0, logic [7:0] d = 0);
    @(negedge clk);
    compare();
    wr_en = w; wr_addr = a; wr_data = d;
    apu_ce = ce_alt ? ~apu_ce : 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    vol_in = 4'd9; len_nz = 1;
    cur_req = "R1";
    idle(4);
    @(negedge clk); rst_n = 1;
    chk("R1", "sample after reset", sample, 0);
    cyc(1, 0, 8'h80);
    cur_req = "R7"; cyc(1, 2, 8'd20);
    cur_req = "R6"; cyc(1, 3, 8'b00101_000);
    cur_req = "R2"; idle(8 * 21 * 2 + 30);
    cur_req = "R3"; idle(200);
    cur_req = "R5"; cyc(1, 0, 8'hC0); idle(150);
    cur_req = "R4"; cyc(1, 0, 8'h40); idle(400);
    cyc(1, 0, 8'h00); idle(400);
    cyc(1, 0, 8'hC0);
    cur_req = "R2"; ce_alt = 0; idle(60); ce_alt = 1; idle(100);
    cur_req = "R6"; idle(13); cyc(1, 3, 8'b11111_000); idle(100);
    cyc(1, 3, 8'b00011_000); cyc(1, 3, 8'b01010_000); idle(60);
    cur_req = "R8"; cyc(1, 2, 8'd8); cyc(1, 3, 8'b00001_000); vol_in = 4'd15; idle(300);
    cyc(1, 2, 8'd7); idle(200);
    cyc(1, 2, 8'd8); sweep_mute = 1; idle(100); sweep_mute = 0;
    len_nz = 0; idle(100); len_nz = 1; vol_in = 4'd3; idle(100);
    cur_req = "R10"; cyc(1, 1, 8'hFF); idle(5); cyc(1, 1, 8'h07); idle(200);
    cur_req = "R9"; cyc(1, 3, 8'b10101_001); idle(40); cyc(1, 2, 8'h00); idle(300);
    cyc(1, 3, 8'b00000_000); cyc(1, 2, 8'd12); idle(400);
    @(negedge clk); compare();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule